// File: doc/BRIEF.md
# Shadow-Loaded Precision Time Counter

This block keeps network time for a port running from a 125 MHz clock. Every cycle it adds a programmable frequency word, holding nanoseconds with 4 integer and 28 fractional bits, to a fractional accumulator. The integer carry out of that sum advances two views of time by the same amount. One view is a seconds/nanoseconds time code that rolls over once per second. The other is a free-running nanosecond counter.

Software never writes live time directly. It fills shadow registers through a 16-bit host port and chooses with a load mask which of them to commit. It then raises a framesync event, and on that event every selected shadow value takes effect on the same clock edge. A framesync comes either from a control bit or from a rising edge on an external sync input. The same event can also freeze the present time into heartbeat registers, so software reads one coherent seconds/nanoseconds pair.

Host register map (word addresses): 0/1 frequency shadow low/high half; 2/3/4 counter shadow, 16+16+12 bits of nanoseconds divided by 16; 5/6 time-code nanoseconds low/high; 7/8/9 time-code seconds, low to high; 10 load mask; 11 persistent load control; 12 engine control; 14 heartbeat control; 16/17 heartbeat nanoseconds low/high; 18/19 heartbeat seconds bits 15:0 and 31:16. Reads of any other address return zero.

Top module: `ptp_nco_clock`

## Requirements
- R1: After reset the frequency word is 0x8000_0000, the counter, seconds and nanoseconds are zero, and each clock adds exactly 8 ns to the counter and the nanoseconds.
- R2: Each cycle the fraction plus the frequency word gives an integer step that is added to both the counter and the nanoseconds. With word 0x8800_0000 and a cleared fraction, the steps run 8, 9, 8, 9.
- R3: Writes to the frequency shadow have no effect until a framesync. On a framesync the frequency word is loaded when load-mask bit 6 or persistent-control bit 6 is set.
- R4: On a framesync with load-mask bit 7 set, the counter becomes {word4[11:0], word3, word2, 4'b0} and the fraction is cleared.
- R5: On a framesync, the time code loads nanoseconds {word6, word5} and seconds {word9, word8, word7} only when load-mask bit 10 and engine-control bit 1 (init) are both set.
- R6: A framesync taken while init is set clears the load mask to zero. Without init the mask keeps its value.
- R7: When the nanoseconds plus the step reach 1,000,000,000, the nanoseconds take the excess and the seconds increment by one.
- R8: Engine-control bit 0 raises a framesync only on its 0-to-1 transition. Holding it at 1 raises no further events.
- R9: A rising edge on sync_in is a framesync only while engine-control bit 3 is set. Otherwise it is ignored.
- R10: With engine-control bit 2 (capture) set, a framesync copies the nanoseconds and the low 32 bits of the seconds, as held in the cycle of the event, into the heartbeat registers and sets fsync_irq.
- R11: While heartbeat-control bit 10 (read start) is set, captures leave the heartbeat registers and fsync_irq untouched. Writing heartbeat control with bit 11 (read end) clears fsync_irq.
- R12: A framesync with an empty load mask and persistent bit 6 clear changes neither the frequency nor the time. It only captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz time base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host register word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr (combinational) |
| sync_in | input | 1 | External framesync input, rising-edge active |
| tod_sec | output | 48 | Time code seconds |
| tod_nsec | output | 32 | Time code nanoseconds |
| nco_time | output | 48 | Free-running nanosecond counter |
| fsync_irq | output | 1 | Framesync capture status |

## Verification
The bench builds the block with its default parameters. These are a 5-bit address, the 8 ns nominal word and a one-billion nanosecond rollover. So the rollover is reached by loading a time code four nanoseconds short of the limit, not by waiting. The 0x8800_0000 and 0x9000_0000 frequency words show both fractional alternation and a whole-number change of step. Captured heartbeat values are compared with the time the outputs show in the cycle of each event.

// File: rtl/ptp_nco_clock.sv
module ptp_nco_clock #(
  parameter int unsigned ADDR_W   = 5,
  parameter logic [31:0] FREQ_NOM = 32'h8000_0000,
  parameter logic [31:0] ROLL_NS  = 32'd1_000_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic              sync_in,
  output logic [47:0]       tod_sec,
  output logic [31:0]       tod_nsec,
  output logic [47:0]       nco_time,
  output logic              fsync_irq
);

  localparam logic [ADDR_W-1:0] A_FRQ_LO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FRQ_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CNT0   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CNT1   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CNT2   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TC0    = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_KEEP   = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] A_ENG    = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_HBC    = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] A_HB0    = ADDR_W'(16);
  localparam int unsigned       TC_WORDS = 5;
  localparam int unsigned       HB_WORDS = 4;

  logic [15:0] sh_frq_lo, sh_frq_hi, sh_cnt0, sh_cnt1;
  logic [11:0] sh_cnt2;
  logic [15:0] sh_tc [TC_WORDS];
  logic [15:0] hb    [HB_WORDS];
  logic [15:0] load_mask, load_keep;
  logic [3:0]  eng;
  logic [1:0]  hb_ctrl;
  logic [31:0] freq;
  logic [27:0] frac;
  logic        cpu_q, sync_q;

  wire fs_cpu = eng[0] & ~cpu_q;
  wire fs_ext = eng[3] & sync_in & ~sync_q;
  wire fs     = fs_cpu | fs_ext;
  wire ld_freq = fs & (load_mask[6] | load_keep[6]);
  wire ld_cnt  = fs & load_mask[7];
  wire ld_tc   = fs & load_mask[10] & eng[1];
  wire do_cap  = fs & eng[2] & ~hb_ctrl[0];

  wire [32:0] acc    = {5'd0, frac} + {1'b0, freq};
  wire [4:0]  step   = acc[32:28];
  wire [32:0] ns_sum = {1'b0, tod_nsec} + 33'(step);
  wire        wrap   = ns_sum >= {1'b0, ROLL_NS};

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return host_wr && host_addr == a;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_frq_lo <= FREQ_NOM[15:0];
      sh_frq_hi <= FREQ_NOM[31:16];
      sh_cnt0   <= '0;
      sh_cnt1   <= '0;
      sh_cnt2   <= '0;
      for (int i = 0; i < TC_WORDS; i++) sh_tc[i] <= '0;
      load_mask <= '0;
      load_keep <= '0;
      eng       <= '0;
      hb_ctrl   <= '0;
      fsync_irq <= 1'b0;
      cpu_q     <= 1'b0;
      sync_q    <= 1'b0;
    end else begin
      cpu_q  <= eng[0];
      sync_q <= sync_in;
      if (hit(A_FRQ_LO)) sh_frq_lo <= host_wdata;
      if (hit(A_FRQ_HI)) sh_frq_hi <= host_wdata;
      if (hit(A_CNT0))   sh_cnt0   <= host_wdata;
      if (hit(A_CNT1))   sh_cnt1   <= host_wdata;
      if (hit(A_CNT2))   sh_cnt2   <= host_wdata[11:0];
      for (int i = 0; i < TC_WORDS; i++)
        if (hit(A_TC0 + ADDR_W'(i))) sh_tc[i] <= host_wdata;
      if (hit(A_KEEP)) load_keep <= host_wdata;
      if (hit(A_ENG))  eng       <= host_wdata[3:0];
      if (hit(A_MASK)) load_mask <= host_wdata;
      if (fs && eng[1]) load_mask <= '0;
      if (hit(A_HBC)) begin
        hb_ctrl <= host_wdata[11:10];
        if (host_wdata[11]) fsync_irq <= 1'b0;
      end
      if (do_cap) fsync_irq <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq     <= FREQ_NOM;
      frac     <= '0;
      nco_time <= '0;
      tod_sec  <= '0;
      tod_nsec <= '0;
      for (int i = 0; i < HB_WORDS; i++) hb[i] <= '0;
    end else begin
      if (ld_freq) freq <= {sh_frq_hi, sh_frq_lo};
      if (ld_cnt) begin
        nco_time <= {sh_cnt2, sh_cnt1, sh_cnt0, 4'd0};
        frac     <= '0;
      end else begin
        nco_time <= nco_time + 48'(step);
        frac     <= acc[27:0];
      end
      if (ld_tc) begin
        tod_nsec <= {sh_tc[1], sh_tc[0]};
        tod_sec  <= {sh_tc[4], sh_tc[3], sh_tc[2]};
      end else if (wrap) begin
        tod_nsec <= ns_sum[31:0] - ROLL_NS;
        tod_sec  <= tod_sec + 48'd1;
      end else begin
        tod_nsec <= ns_sum[31:0];
      end
      if (do_cap) begin
        hb[0] <= tod_nsec[15:0];
        hb[1] <= tod_nsec[31:16];
        hb[2] <= tod_sec[15:0];
        hb[3] <= tod_sec[31:16];
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr >= A_TC0 && host_addr < A_TC0 + ADDR_W'(TC_WORDS))
      host_rdata = sh_tc[3'(host_addr - A_TC0)];
    if (host_addr >= A_HB0 && host_addr < A_HB0 + ADDR_W'(HB_WORDS))
      host_rdata = hb[2'(host_addr - A_HB0)];
    case (host_addr)
      A_FRQ_LO: host_rdata = sh_frq_lo;
      A_FRQ_HI: host_rdata = sh_frq_hi;
      A_CNT0:   host_rdata = sh_cnt0;
      A_CNT1:   host_rdata = sh_cnt1;
      A_CNT2:   host_rdata = {4'd0, sh_cnt2};
      A_MASK:   host_rdata = load_mask;
      A_KEEP:   host_rdata = load_keep;
      A_ENG:    host_rdata = {12'd0, eng};
      A_HBC:    host_rdata = {4'd0, hb_ctrl, 10'd0};
      default:  ;
    endcase
  end

  wire [63:0] hb_all = {hb[3], hb[2], hb[1], hb[0]};

  // R7
  nsec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_tc && tod_nsec < ROLL_NS) |=> tod_nsec < ROLL_NS);

  // R7
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_tc |=> (tod_sec == $past(tod_sec) || tod_sec == $past(tod_sec) + 48'd1));

  // R3
  freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fs |=> $stable(freq));

  // R2
  nco_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_cnt |=> (nco_time - $past(nco_time)) <= 48'd16);

  // R11
  hb_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hb_ctrl[0] |=> $stable(hb_all));

endmodule

// File: tb/test_ptp_nco_clock.sv
module test_ptp_nco_clock;
  localparam int CLK_PERIOD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        sync_in = 1'b0;
  logic [47:0] tod_sec;
  logic [31:0] tod_nsec;
  logic [47:0] nco_time;
  logic        fsync_irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] cap_ns;
  logic [47:0] cap_sec;

  ptp_nco_clock i_ptp_nco_clock (
    .clk, .rst_n, .host_wr, .host_addr, .host_wdata, .host_rdata,
    .sync_in, .tod_sec, .tod_nsec, .nco_time, .fsync_irq
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic fire(input logic [15:0] ctrl);
    wr(5'd12, ctrl | 16'h1);
    cap_ns = tod_nsec;
    cap_sec = tod_sec;
    wr(5'd12, ctrl & ~16'h1);
  endtask

  task automatic t_reset();
    chk("R1 counter at reset", 64'(nco_time), 64'd0);
    chk("R1 seconds at reset", 64'(tod_sec), 64'd0);
    chk("R1 irq at reset", 64'(fsync_irq), 64'd0);
    repeat (5) @(negedge clk);
    chk("R1 counter 8ns/cycle", 64'(nco_time), 64'd40);
    chk("R1 nsec 8ns/cycle", 64'(tod_nsec), 64'd40);
  endtask

  task automatic t_counter_load();
    logic [47:0] exp_cnt;
    logic [31:0] t0;
    wr(5'd0, 16'h0000); wr(5'd1, 16'h8800);
    wr(5'd2, 16'h1234); wr(5'd3, 16'h5678); wr(5'd4, 16'h0ABC);
    wr(5'd10, 16'h00C0);
    fire(16'h0);
    exp_cnt = 48'hABC5_6781_2340;
    chk("R4 counter load", 64'(nco_time), 64'(exp_cnt));
    t0 = tod_nsec;
    repeat (4) @(negedge clk);
    chk("R2 counter 8.5ns steps", 64'(nco_time), 64'(exp_cnt + 48'd34));
    chk("R2 nsec 8.5ns steps", 64'(tod_nsec), 64'(t0 + 32'd34));
    wr(5'd1, 16'h8000); wr(5'd10, 16'h0040);
    fire(16'h0);
  endtask

  task automatic t_shadow_capture();
    logic [47:0] n0;
    logic [15:0] lo, hi;
    wr(5'd1, 16'h9000); wr(5'd10, 16'h0000);
    fire(16'h4);
    chk("R12 time not disturbed", 64'(tod_nsec), 64'(cap_ns + 32'd8));
    n0 = nco_time;
    repeat (3) @(negedge clk);
    chk("R3 shadow freq not applied", 64'(nco_time), 64'(n0 + 48'd24));
    chk("R10 irq set", 64'(fsync_irq), 64'd1);
    rd(5'd16, lo); rd(5'd17, hi);
    chk("R10 heartbeat nsec", 64'({hi, lo}), 64'(cap_ns));
    rd(5'd18, lo);
    chk("R10 heartbeat sec", 64'(lo), 64'(cap_sec[15:0]));
    n0 = {16'd0, cap_ns};
    wr(5'd14, 16'h0400);
    fire(16'h4);
    rd(5'd16, lo); rd(5'd17, hi);
    chk("R11 heartbeat frozen", 64'({hi, lo}), 64'(n0[31:0]));
    wr(5'd14, 16'h0800);
    chk("R11 read end clears irq", 64'(fsync_irq), 64'd0);
    wr(5'd14, 16'h0000);
  endtask

  task automatic t_persist();
    logic [47:0] n0;
    wr(5'd11, 16'h0040);
    fire(16'h0);
    n0 = nco_time;
    repeat (4) @(negedge clk);
    chk("R3 persistent freq load", 64'(nco_time), 64'(n0 + 48'd36));
    wr(5'd1, 16'h8000);
    fire(16'h0);
    wr(5'd11, 16'h0000);
    n0 = nco_time;
    repeat (2) @(negedge clk);
    chk("R3 freq restored", 64'(nco_time), 64'(n0 + 48'd16));
  endtask

  task automatic t_timecode();
    logic [15:0] m;
    wr(5'd5, 16'hC9FC); wr(5'd6, 16'h3B9A);
    wr(5'd7, 16'h0005); wr(5'd8, 16'h0000); wr(5'd9, 16'h0000);
    wr(5'd10, 16'h0400);
    fire(16'h0);
    chk("R5 no load without init", 64'(tod_sec), 64'd0);
    rd(5'd10, m);
    chk("R6 mask kept without init", 64'(m), 64'h0400);
    fire(16'h2);
    chk("R5 nsec loaded", 64'(tod_nsec), 64'd999_999_996);
    chk("R5 sec loaded", 64'(tod_sec), 64'd5);
    rd(5'd10, m);
    chk("R6 mask cleared by init", 64'(m), 64'd0);
    @(negedge clk);
    chk("R7 nsec rollover", 64'(tod_nsec), 64'd4);
    chk("R7 sec increment", 64'(tod_sec), 64'd6);
    wr(5'd12, 16'h0);
  endtask

  task automatic t_cpu_hold();
    wr(5'd12, 16'h5);
    @(negedge clk);
    chk("R8 rising edge fires", 64'(fsync_irq), 64'd1);
    wr(5'd14, 16'h0800); wr(5'd14, 16'h0000);
    repeat (5) @(negedge clk);
    chk("R8 held bit no retrigger", 64'(fsync_irq), 64'd0);
    wr(5'd12, 16'h0);
  endtask

  task automatic t_sync_in();
    logic [15:0] lo, hi;
    logic [31:0] e_ns;
    wr(5'd12, 16'h4);
    sync_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 sync_in ignored when disabled", 64'(fsync_irq), 64'd0);
    sync_in = 1'b0;
    @(negedge clk);
    wr(5'd12, 16'hC);
    e_ns = tod_nsec;
    sync_in = 1'b1;
    @(negedge clk);
    chk("R9 sync_in fires", 64'(fsync_irq), 64'd1);
    rd(5'd16, lo); rd(5'd17, hi);
    chk("R9 sync_in capture", 64'({hi, lo}), 64'(e_ns));
    sync_in = 1'b0;
    wr(5'd14, 16'h0800); wr(5'd14, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_counter_load();
    t_shadow_capture();
    t_persist();
    t_timecode();
    t_cpu_hold();
    t_sync_in();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule